// File: doc/BRIEF.md
# DMA Burst Request Planner

This block sits between a DMA engine and a host-bus master. It accepts one transfer request at a time. A request gives a start address, a total number of beats and a direction, transmit or receive. The block breaks the request into a stream of burst commands. Each command carries an address, a beat count and a bus burst type, and it is handed downstream over a valid/ready handshake. The address advances by four bytes per beat, because the data path is 32 bits wide.

The largest burst comes from a programmed length. Transmit has its own length. Receive can have a separate length when split-length mode is on; otherwise both directions share the transmit length. The length is also capped at half of the FIFO depth, which is a parameter. In fixed-burst mode the commands keep to the four fixed burst shapes. In the other mode, any burst of more than one beat is an incrementing burst. A length setting that is not allowed raises an error flag, and the request is refused.

The controller has two states. IDLE accepts a request; the move from IDLE to ISSUE happens when a legal, non-empty request is taken. ISSUE presents commands; the move from ISSUE back to IDLE happens when the last command of the request is accepted. Every other cycle stays in its current state.

Top module: `burst_planner`

## Requirements
- R1: The selected length must be 1, 2, 4, 8, 16 or 32. Any other value drives `cfg_err` high, and a request presented with it is not taken: no command follows and `done` does not pulse.
- R2: When `cfg_split`=1 and `req_dir`=1 (receive), the selected length is `cfg_len_rx`. In every other case it is `cfg_len_tx`.
- R3: When fixed mode is off, each command moves min(beats remaining, effective maximum) beats. A one-beat command has `cmd_burst`=3'b000 (SINGLE); a longer one has 3'b001 (INCR).
- R4: When fixed mode is on, each command moves the largest of 16, 8, 4 or 1 that does not exceed min(beats remaining, effective maximum). The burst codes are INCR16=3'b111, INCR8=3'b101, INCR4=3'b011 and SINGLE=3'b000, and INCR is never issued in this mode.
- R5: The effective maximum is the smaller of the selected length and FIFO_DEPTH/2.
- R6: The first command carries the start address. Each later command carries the previous address plus 4 × the previous beat count.
- R7: While `cmd_valid`=1 and `cmd_ready`=0, the command fields hold steady and `cmd_valid` stays high.
- R8: `done` is high for exactly the one cycle that follows the acceptance of the request's last command. `req_ready` is already high in that cycle.
- R9: A request is taken only while `req_ready`=1. `req_ready` is low whenever commands are pending. A request of zero beats is not taken and produces nothing.
- R10: After reset, `req_ready`=1, `cmd_valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_dir | input | 1 | Direction: 0 transmit, 1 receive |
| req_addr | input | ADDR_W | Start byte address |
| req_beats | input | CNT_W | Total beats to move |
| cfg_len_tx | input | LEN_W | Common / transmit maximum burst length |
| cfg_len_rx | input | LEN_W | Receive maximum, used when split is on |
| cfg_split | input | 1 | Split-length enable |
| cfg_fixed | input | 1 | Fixed-burst enable |
| req_ready | output | 1 | Idle, able to take a request |
| cfg_err | output | 1 | Selected length is not allowed |
| cmd_valid | output | 1 | A command is presented |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_addr | output | ADDR_W | Command start address |
| cmd_beats | output | LEN_W | Command beat count |
| cmd_burst | output | 3 | Burst type code |
| done | output | 1 | Request finished pulse |

## Verification
Two events can fall in the same cycle: the `done` pulse for one request and the acceptance of the next request, because `req_ready` rises together with `done`. The bench provokes this by holding a second request valid while the first one is still issuing. It then judges the result per cycle against a reference model. The model expects `done` high while `req_ready` is high, and it expects the second request's first command at its own start address in the following cycle. Two instances with different FIFO depths get the same traffic, and irregular `cmd_ready` stalls fall onto the last command.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [2:0] {
        BT_SINGLE = 3'b000,
        BT_INCR   = 3'b001,
        BT_INCR4  = 3'b011,
        BT_INCR8  = 3'b101,
        BT_INCR16 = 3'b111
    } burst_e;

    typedef enum logic {
        ST_IDLE,
        ST_ISSUE
    } state_e;
endpackage

// File: rtl/bp_len_check.sv
module bp_len_check #(
    parameter int LEN_W = 6,
    parameter int HALF  = 32
) (
    input  logic [LEN_W-1:0] len,
    output logic             legal,
    output logic [LEN_W-1:0] eff
);
    always_comb begin
        legal = (len != '0) && ((len & (len - 1'b1)) == '0) && (len <= LEN_W'(32));
        eff   = (32'(len) > HALF) ? LEN_W'(HALF) : len;
    end
endmodule

// File: rtl/bp_chunk.sv
module bp_chunk
    import bp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LEN_W = 6
) (
    input  logic [CNT_W-1:0] rem,
    input  logic [LEN_W-1:0] max_len,
    input  logic             fixed,
    output logic [LEN_W-1:0] beats,
    output burst_e           burst
);
    logic [LEN_W-1:0] n;

    always_comb begin
        n = (rem < CNT_W'(max_len)) ? rem[LEN_W-1:0] : max_len;
        if (fixed) begin
            if (n >= LEN_W'(16)) begin
                beats = LEN_W'(16);
                burst = BT_INCR16;
            end else if (n >= LEN_W'(8)) begin
                beats = LEN_W'(8);
                burst = BT_INCR8;
            end else if (n >= LEN_W'(4)) begin
                beats = LEN_W'(4);
                burst = BT_INCR4;
            end else begin
                beats = LEN_W'(1);
                burst = BT_SINGLE;
            end
        end else begin
            beats = n;
            burst = (n == LEN_W'(1)) ? BT_SINGLE : BT_INCR;
        end
    end
endmodule

// File: rtl/burst_planner.sv
module burst_planner
    import bp_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int CNT_W          = 16,
    parameter int LEN_W          = 6,
    parameter int FIFO_DEPTH     = 64,
    parameter int BYTES_PER_BEAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_dir,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_beats,
    input  logic [LEN_W-1:0]  cfg_len_tx,
    input  logic [LEN_W-1:0]  cfg_len_rx,
    input  logic              cfg_split,
    input  logic              cfg_fixed,
    output logic              req_ready,
    output logic              cfg_err,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_beats,
    output logic [2:0]        cmd_burst,
    output logic              done
);
    localparam int HALF = FIFO_DEPTH / 2;

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic [LEN_W-1:0]  max_q;
    logic              fixed_q;
    logic              done_q;

    logic [LEN_W-1:0]  sel_len, eff_len, chunk_beats;
    logic              legal, take, fire, last;
    burst_e            chunk_burst;

    assign sel_len = (cfg_split && req_dir) ? cfg_len_rx : cfg_len_tx;

    bp_len_check #(.LEN_W(LEN_W), .HALF(HALF)) u_len (
        .len   (sel_len),
        .legal (legal),
        .eff   (eff_len)
    );

    bp_chunk #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_chunk (
        .rem     (rem_q),
        .max_len (max_q),
        .fixed   (fixed_q),
        .beats   (chunk_beats),
        .burst   (chunk_burst)
    );

    assign take = req_valid && (state_q == ST_IDLE) && legal && (req_beats != '0);
    assign fire = (state_q == ST_ISSUE) && cmd_ready;
    assign last = (rem_q == CNT_W'(chunk_beats));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take) state_d = ST_ISSUE;
            ST_ISSUE: if (fire && last) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request context and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rem_q   <= '0;
            max_q   <= '0;
            fixed_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= fire && last;
            if (take) begin
                addr_q  <= req_addr;
                rem_q   <= req_beats;
                max_q   <= eff_len;
                fixed_q <= cfg_fixed;
            end else if (fire) begin
                addr_q <= addr_q + ADDR_W'(chunk_beats) * ADDR_W'(BYTES_PER_BEAT);
                rem_q  <= rem_q - CNT_W'(chunk_beats);
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        cmd_valid = (state_q == ST_ISSUE);
        cfg_err   = !legal;
        cmd_addr  = addr_q;
        cmd_beats = chunk_beats;
        cmd_burst = chunk_burst;
        done      = done_q;
    end
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
    parameter int ADDR_W         = 32,
    parameter int CNT_W          = 16,
    parameter int LEN_W          = 6,
    parameter int HALF           = 32,
    parameter int BYTES_PER_BEAT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cfg_err,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [LEN_W-1:0]  cmd_beats,
    input logic [2:0]        cmd_burst,
    input logic              done,
    input logic              fixed_q,
    input logic [CNT_W-1:0]  rem_q
);
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_beats) && $stable(cmd_burst));

    a_r4_no_incr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && fixed_q |-> cmd_burst != 3'b001);

    a_r5_beats_capped: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_beats != '0) && (int'(cmd_beats) <= HALF));

    a_r3_single_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_burst == 3'b000 |-> cmd_beats == LEN_W'(1));

    a_r8_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cmd_valid && cmd_ready) && req_ready);

    a_r1_err_refused: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && cfg_err |=> !cmd_valid);

    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && (rem_q != CNT_W'(cmd_beats)) |=>
        cmd_addr == $past(cmd_addr) + ADDR_W'($past(cmd_beats)) * ADDR_W'(BYTES_PER_BEAT));

    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready);
endmodule

bind burst_planner bp_checker #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
    .HALF(FIFO_DEPTH / 2), .BYTES_PER_BEAT(BYTES_PER_BEAT)
) u_sva (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cfg_err(cfg_err), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_beats(cmd_beats), .cmd_burst(cmd_burst),
    .done(done), .fixed_q(fixed_q), .rem_q(rem_q)
);

// File: tb/sim_burst_planner.sv
`timescale 1ns/1ps
module sim_burst_planner;
    typedef struct {
        logic [31:0] addr;
        int          beats;
        logic [2:0]  bt;
        bit          last;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rv [2];
    logic        dir = 1'b0;
    logic [31:0] raddr = '0;
    logic [15:0] rbeats = '0;
    logic [5:0]  ltx = 6'd1, lrx = 6'd1;
    logic        split = 1'b0, fixed = 1'b0;
    logic        rr [2], cerr [2], cv [2], cr [2], dn [2];
    logic [31:0] ca [2];
    logic [5:0]  cb [2];
    logic [2:0]  ct [2];

    exp_t q0[$], q1[$];
    bit   exp_done [2];
    bit   run = 0;
    int   checks = 0, errors = 0, cyc = 0;

    always #4 clk = ~clk;

    burst_planner u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_dir(dir), .req_addr(raddr),
        .req_beats(rbeats), .cfg_len_tx(ltx), .cfg_len_rx(lrx), .cfg_split(split),
        .cfg_fixed(fixed), .req_ready(rr[0]), .cfg_err(cerr[0]), .cmd_valid(cv[0]),
        .cmd_ready(cr[0]), .cmd_addr(ca[0]), .cmd_beats(cb[0]), .cmd_burst(ct[0]), .done(dn[0]));

    burst_planner #(.FIFO_DEPTH(16)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_dir(dir), .req_addr(raddr),
        .req_beats(rbeats), .cfg_len_tx(ltx), .cfg_len_rx(lrx), .cfg_split(split),
        .cfg_fixed(fixed), .req_ready(rr[1]), .cfg_err(cerr[1]), .cmd_valid(cv[1]),
        .cmd_ready(cr[1]), .cmd_addr(ca[1]), .cmd_beats(cb[1]), .cmd_burst(ct[1]), .done(dn[1]));

    task automatic fail(input string tag, input int i, input string what, input longint act, input longint exp);
        errors++;
        $display("FAIL %s inst%0d %s actual %0h expected %0h", tag, i, what, act, exp);
    endtask

    task automatic chk(input bit ok, input string tag, input int i, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) fail(tag, i, what, act, exp);
    endtask

    // reference model: expected command list for one request
    task automatic plan(ref exp_t q[$], input int cap, input logic [31:0] addr, input int beats,
                        input int len, input bit fx, input string tag);
        int m = (len < cap) ? len : cap;
        int rem = beats;
        logic [31:0] a = addr;
        while (rem > 0) begin
            exp_t e;
            int n = (rem < m) ? rem : m;
            if (fx) begin
                if (n >= 16) begin n = 16; e.bt = 3'b111; end
                else if (n >= 8) begin n = 8; e.bt = 3'b101; end
                else if (n >= 4) begin n = 4; e.bt = 3'b011; end
                else begin n = 1; e.bt = 3'b000; end
            end else e.bt = (n == 1) ? 3'b000 : 3'b001;
            e.addr = a; e.beats = n; e.tag = tag;
            rem -= n; a += 32'(n * 4);
            e.last = (rem == 0);
            q.push_back(e);
        end
    endtask

    task automatic mon(input int i, ref exp_t q[$]);
        chk(dn[i] == exp_done[i], "R8", i, "done", dn[i], exp_done[i]);
        if (dn[i]) chk(rr[i] == 1'b1, "R8", i, "req_ready with done", rr[i], 1);
        exp_done[i] = 0;
        if (cv[i]) begin
            chk(rr[i] == 1'b0, "R9", i, "req_ready while busy", rr[i], 0);
            if (q.size() == 0) begin
                checks++;
                fail("R9", i, "unexpected command", ca[i], 0);
            end else begin
                chk(ca[i] == q[0].addr, "R6", i, "addr", ca[i], q[0].addr);
                chk(int'(cb[i]) == q[0].beats, q[0].tag, i, "beats", cb[i], q[0].beats);
                chk(ct[i] == q[0].bt, q[0].tag, i, "burst", ct[i], q[0].bt);
                if (cr[i]) begin
                    exp_done[i] = q[0].last;
                    void'(q.pop_front());
                end
            end
        end
    endtask

    // per-clock comparison; stall pattern R7 chosen before comparing
    always @(negedge clk) if (run) begin
        cr[0] = (cyc % 4) != 1;
        cr[1] = (cyc % 5) != 2;
        mon(0, q0);
        mon(1, q1);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic send(input bit d, input logic [31:0] a, input int n, input int lt, input int lr,
                        input bit sp, input bit fx, input string tag);
        int len = (sp && d) ? lr : lt;
        bit acc [2];
        plan(q0, 32, a, n, len, fx, tag);
        plan(q1, 8, a, n, len, fx, tag);
        dir = d; raddr = a; rbeats = 16'(n); ltx = 6'(lt); lrx = 6'(lr); split = sp; fixed = fx;
        rv[0] = 1'b1; rv[1] = 1'b1;
        while (rv[0] || rv[1]) begin
            for (int i = 0; i < 2; i++) acc[i] = rv[i] && rr[i];
            @(negedge clk);
            for (int i = 0; i < 2; i++) if (acc[i]) rv[i] = 1'b0;
        end
    endtask

    task automatic wait_idle();
        while (q0.size() != 0 || q1.size() != 0 || !rr[0] || !rr[1]) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // request that must be refused; monitor flags any command or done
    task automatic refuse(input bit d, input int n, input int lt, input int lr, input bit sp,
                          input bit err_exp, input string tag);
        dir = d; raddr = 32'h40; rbeats = 16'(n); ltx = 6'(lt); lrx = 6'(lr); split = sp; fixed = 1'b0;
        rv[0] = 1'b1; rv[1] = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            for (int i = 0; i < 2; i++) begin
                chk(cerr[i] == err_exp, tag, i, "cfg_err", cerr[i], err_exp);
                chk(rr[i] == 1'b1, tag, i, "still idle", rr[i], 1);
            end
        end
        rv[0] = 1'b0; rv[1] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        rv[0] = 1'b0; rv[1] = 1'b0; cr[0] = 1'b0; cr[1] = 1'b0;
        exp_done[0] = 0; exp_done[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(rr[i] == 1'b1, "R10", i, "req_ready", rr[i], 1);
            chk(cv[i] == 1'b0, "R10", i, "cmd_valid", cv[i], 0);
            chk(dn[i] == 1'b0, "R10", i, "done", dn[i], 0);
        end
        run = 1;

        send(0, 32'h1000, 20, 8, 1, 0, 0, "R3");  wait_idle();
        send(0, 32'h2000, 3, 1, 1, 0, 0, "R3");   wait_idle();
        send(0, 32'h3000, 45, 32, 1, 0, 1, "R4"); wait_idle();
        send(1, 32'h3800, 5, 2, 1, 0, 1, "R4");   wait_idle();
        send(0, 32'h4000, 70, 32, 1, 0, 0, "R5"); wait_idle();
        send(1, 32'h5000, 10, 16, 4, 1, 0, "R2"); wait_idle();
        send(1, 32'h6000, 10, 16, 4, 0, 0, "R2"); wait_idle();
        send(0, 32'h7000, 10, 16, 2, 1, 0, "R2"); wait_idle();

        refuse(0, 8, 3, 4, 0, 1, "R1");
        refuse(0, 8, 0, 4, 0, 1, "R1");
        refuse(1, 8, 16, 12, 1, 1, "R2");
        refuse(0, 0, 8, 8, 0, 0, "R9");

        // second request held while first issues: done and take coincide (R8)
        send(0, 32'h8000, 12, 4, 1, 0, 0, "R8");
        send(1, 32'h9000, 9, 8, 8, 0, 1, "R8");
        wait_idle();
        send(0, 32'hA000, 33, 16, 1, 0, 1, "R7");
        wait_idle();

        run = 0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule